// File: doc/BRIEF.md
# Shared-Slot Issue Merger

This block sits in front of a bank of reservation-station sets. Each set has one issue slot, and the block combines two sources of work into those slots every cycle. The primary stream arrives already spread across the slots, with a valid bit per slot. Helper (microthread) instructions arrive from a collapsing buffer as a count of waiting entries, with entry 0 the oldest. In each slot the primary instruction has priority. A slot with no primary instruction takes the next unused helper entry, so the free slots are filled with the oldest helper work in ascending slot order. The block returns the number of helper entries it took, and the buffer collapses by that amount.

If the primary stream fills every slot in an accepted cycle, the next cycle is a helper-only cycle, provided helper work is waiting. In that cycle the primary stream is stalled through its ready signal, so its instructions are held upstream and not dropped. No slot ever receives more than one instruction, so the two sources share the fixed issue width and never add to it. Issued slots are registered and appear one clock after the cycle in which they were selected.

Top module: `issue_slot_merger`

## Requirements
- R1: After reset `issue_valid` and `issue_micro` are all zero and `prim_ready` is 1.
- R2: In a cycle with `prim_ready` high, every slot s with `prim_valid[s]` set issues `prim_data` slot s on the next clock, with `issue_valid[s]`=1 and `issue_micro[s]`=0.
- R3: The slots that take no primary instruction are filled with helper entries in ascending slot order. Entry k (bits k*DATA_W upward of `micro_data`, entry 0 the oldest) goes to the k-th such slot, counting from 0 at the lowest slot. A slot filled this way shows `issue_micro`=1 on the next clock.
- R4: `micro_take` equals the smaller of `micro_count` and the number of slots not taken by the primary stream. A slot that receives neither source issues with `issue_valid`=0 and `issue_data` zero.
- R5: If a cycle with `prim_ready` high has all `prim_valid` bits set, the following cycle is a helper-only cycle whenever `micro_count` is nonzero. In that cycle `prim_ready` is 0, every slot counts as free for helper entries, and no primary instruction issues.
- R6: A pending helper-only cycle is skipped when `micro_count` is zero. `prim_ready` then stays 1 and the cycle merges normally.
- R7: A helper-only cycle never lasts longer than one cycle. In the cycle after it, `prim_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prim_valid | input | NUM_SLOTS | Primary instruction present, one bit per slot |
| prim_data | input | NUM_SLOTS*DATA_W | Primary instruction payloads, slot s at bits s*DATA_W upward |
| prim_ready | output | 1 | Primary stream accepted this cycle; low during a helper-only cycle |
| micro_count | input | CNT_W | Number of waiting helper entries |
| micro_data | input | NUM_SLOTS*DATA_W | Helper entries, oldest in entry 0 |
| micro_take | output | CNT_W | Helper entries consumed this cycle |
| issue_valid | output | NUM_SLOTS | Registered: slot carries an instruction |
| issue_micro | output | NUM_SLOTS | Registered: slot instruction came from the helper stream |
| issue_data | output | NUM_SLOTS*DATA_W | Registered slot payloads |

## Verification
`prim_ready` and `micro_take` are combinational in the same cycle. The bench drives its inputs just after a falling edge and samples these two outputs 1 ns later, before the next rising edge. The slot outputs change at the rising edge that follows, so the bench compares them at the next falling edge against the expectation it stored for that cycle, and only then drives the next pattern. The bench keeps its own copy of the pending helper-only flag and advances it at the same point, so the result of each sweep step depends on the step before it, just as it does in the block.

// File: rtl/issue_merge_pkg.sv
package issue_merge_pkg;

  // Helper entries consumed: limited both by free slots and by waiting work.
  function automatic int take_count(input int free_slots, input int waiting);
    return (free_slots < waiting) ? free_slots : waiting;
  endfunction

endpackage

// File: rtl/issue_bubble_ctrl.sv
module issue_bubble_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic prim_all_valid,
  input  logic micro_waiting,
  output logic bubble,
  output logic prim_ready
);

  logic pending_q;
  logic full_fire;

  assign bubble     = pending_q && micro_waiting;
  assign prim_ready = !bubble;
  assign full_fire  = prim_ready && prim_all_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= full_fire;
  end

  AST_BUBBLE_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_fire |=> (!micro_waiting || !prim_ready)); // R5
  AST_BUBBLE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    !micro_waiting |-> prim_ready); // R6
  AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !prim_ready |=> prim_ready); // R7

endmodule

// File: rtl/issue_slot_select.sv
module issue_slot_select #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                          bubble,
  input  logic [NUM_SLOTS-1:0]          prim_valid,
  input  logic [NUM_SLOTS*DATA_W-1:0]   prim_data,
  input  logic [CNT_W-1:0]              micro_count,
  input  logic [NUM_SLOTS*DATA_W-1:0]   micro_data,
  output logic [NUM_SLOTS-1:0]          slot_valid,
  output logic [NUM_SLOTS-1:0]          slot_micro,
  output logic [NUM_SLOTS*DATA_W-1:0]   slot_data,
  output logic [CNT_W-1:0]              micro_take
);
  import issue_merge_pkg::*;

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] free_slot;
  logic [NUM_SLOTS-1:0] use_prim;
  logic [CNT_W-1:0]     rank [NUM_SLOTS+1];
  logic [DATA_W-1:0]    mq   [NUM_SLOTS];

  assign rank[0] = '0;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [IDX_W-1:0] pick;
    assign mq[s]        = micro_data[s*DATA_W +: DATA_W];
    assign use_prim[s]  = !bubble && prim_valid[s];
    assign free_slot[s] = !use_prim[s];
    // running count of free slots below this one; never exceeds s
    assign rank[s+1]    = rank[s] + CNT_W'(free_slot[s]);
    assign pick         = rank[s][IDX_W-1:0];
    assign slot_micro[s] = free_slot[s] && (rank[s] < micro_count);
    assign slot_valid[s] = use_prim[s] || slot_micro[s];
    assign slot_data[s*DATA_W +: DATA_W] =
      use_prim[s]   ? prim_data[s*DATA_W +: DATA_W] :
      slot_micro[s] ? mq[pick] : '0;
  end

  assign micro_take = CNT_W'(take_count(int'(rank[NUM_SLOTS]), int'(micro_count)));

endmodule

// File: rtl/issue_slot_merger.sv
module issue_slot_merger #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        prim_valid,
  input  logic [NUM_SLOTS*DATA_W-1:0] prim_data,
  output logic                        prim_ready,
  input  logic [CNT_W-1:0]            micro_count,
  input  logic [NUM_SLOTS*DATA_W-1:0] micro_data,
  output logic [CNT_W-1:0]            micro_take,
  output logic [NUM_SLOTS-1:0]        issue_valid,
  output logic [NUM_SLOTS-1:0]        issue_micro,
  output logic [NUM_SLOTS*DATA_W-1:0] issue_data
);

  logic                        bubble;
  logic                        prim_all_valid;
  logic                        micro_waiting;
  logic [NUM_SLOTS-1:0]        sel_valid;
  logic [NUM_SLOTS-1:0]        sel_micro;
  logic [NUM_SLOTS*DATA_W-1:0] sel_data;

  assign prim_all_valid = &prim_valid;
  assign micro_waiting  = (micro_count != '0);

  issue_bubble_ctrl u_bubble (
    .clk            (clk),
    .rst_n          (rst_n),
    .prim_all_valid (prim_all_valid),
    .micro_waiting  (micro_waiting),
    .bubble         (bubble),
    .prim_ready     (prim_ready)
  );

  issue_slot_select #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W)
  ) u_select (
    .bubble      (bubble),
    .prim_valid  (prim_valid),
    .prim_data   (prim_data),
    .micro_count (micro_count),
    .micro_data  (micro_data),
    .slot_valid  (sel_valid),
    .slot_micro  (sel_micro),
    .slot_data   (sel_data),
    .micro_take  (micro_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_valid <= '0;
      issue_micro <= '0;
      issue_data  <= '0;
    end else begin
      issue_valid <= sel_valid;
      issue_micro <= sel_micro;
      issue_data  <= sel_data;
    end
  end

  AST_TAKE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(issue_micro) == int'($past(micro_take)))); // R4
  AST_PRIM_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_ready && prim_valid[0]) |=> (issue_valid[0] && !issue_micro[0])); // R2

endmodule

// File: tb/issue_slot_merger_bench.sv
`timescale 1ns/1ps
module issue_slot_merger_bench;

  localparam int N  = 4;
  localparam int DW = 8;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  prim_valid = '0;
  logic [N*DW-1:0] prim_data = '0;
  logic          prim_ready;
  logic [CW-1:0] micro_count = '0;
  logic [N*DW-1:0] micro_data = '0;
  logic [CW-1:0] micro_take;
  logic [N-1:0]  issue_valid;
  logic [N-1:0]  issue_micro;
  logic [N*DW-1:0] issue_data;

  int checks = 0;
  int failures = 0;
  int step_no = 0;

  logic          pend_m = 1'b0;
  logic          have_exp = 1'b0;
  logic [N-1:0]  exp_valid, exp_micro;
  logic [N*DW-1:0] exp_data;

  always #4 clk = ~clk;

  issue_slot_merger #(.NUM_SLOTS(N), .DATA_W(DW)) u_issue_slot_merger (
    .clk(clk), .rst_n(rst_n),
    .prim_valid(prim_valid), .prim_data(prim_data), .prim_ready(prim_ready),
    .micro_count(micro_count), .micro_data(micro_data), .micro_take(micro_take),
    .issue_valid(issue_valid), .issue_micro(issue_micro), .issue_data(issue_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s step=%0d actual=%h expected=%h", req, step_no, act, exp);
    end
  endtask

  task automatic check_issue();
    if (have_exp) begin
      check("R2 primary slots", 64'(issue_valid & ~issue_micro), 64'(exp_valid & ~exp_micro));
      check("R3 helper slots", 64'(issue_micro), 64'(exp_micro));
      check("R3 slot data", 64'(issue_data), 64'(exp_data));
      check("R4 idle slots", 64'(issue_valid), 64'(exp_valid));
    end
  endtask

  task automatic step(input logic [N-1:0] pv, input int mc);
    logic bub;
    int k;
    @(negedge clk);
    check_issue();
    step_no++;
    prim_valid  = pv;
    micro_count = CW'(mc);
    for (int s = 0; s < N; s++) prim_data[s*DW +: DW] = DW'((step_no * 3 + s) & 8'h7F);
    for (int e = 0; e < N; e++) micro_data[e*DW +: DW] = DW'((step_no * 5 + e) | 8'h80);
    #1;
    bub = pend_m && (mc > 0);
    if (pend_m) begin
      if (mc > 0) check("R5 stall after full", 64'(prim_ready), 64'(0));
      else        check("R6 skip without work", 64'(prim_ready), 64'(1));
    end else begin
      check("R7 ready outside stall", 64'(prim_ready), 64'(1));
    end
    k = 0;
    exp_valid = '0; exp_micro = '0; exp_data = '0;
    for (int s = 0; s < N; s++) begin
      if (!bub && pv[s]) begin
        exp_valid[s] = 1'b1;
        exp_data[s*DW +: DW] = prim_data[s*DW +: DW];
      end else if (k < mc) begin
        exp_valid[s] = 1'b1;
        exp_micro[s] = 1'b1;
        exp_data[s*DW +: DW] = micro_data[k*DW +: DW];
        k++;
      end
    end
    check("R4 take count", 64'(micro_take), 64'(k));
    have_exp = 1'b1;
    pend_m = !bub && (pv == {N{1'b1}});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 issue_valid reset", 64'(issue_valid), 64'(0));
    check("R1 issue_micro reset", 64'(issue_micro), 64'(0));
    check("R1 ready reset", 64'(prim_ready), 64'(1));
    rst_n = 1'b1;
    for (int p = 0; p < (1 << N); p++)
      for (int m = 0; m <= N; m++)
        step(N'(p), m);
    // directed: full, then full with no helper work (R6), then stall (R5), then release (R7)
    step({N{1'b1}}, 0);
    step({N{1'b1}}, 0);
    step({N{1'b1}}, 2);
    step({N{1'b1}}, 2);
    step({N{1'b1}}, 7);
    step(N'(4'b0101), 7);
    step('0, 0);
    @(negedge clk);
    check_issue();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule